// File: doc/BRIEF.md
# Burst-Capable 32-bit Bus Target

This block is the target side of a 32-bit expansion card on a two-phase bus. A cycle opens with a start phase, in which the block looks at the address, the memory/I/O qualifier and the write/read line and decides whether the card is addressed. Data then moves in the command phase that follows. While the card is selected, the block announces its data width and its ability to burst. It holds its ready output low to add wait states ahead of each data beat.

A small register array backs every access. Writes change only the byte lanes whose enable is active. Reads drive the whole 32-bit word, with an output enable that stands in for the tri-state driver. The master can take up the burst offer by holding its burst-accept line low. Each accepted beat then moves the block's internal word address up by one (4 bytes), wrapping inside the card's window. A cycle ends when the command line is released or when a new start phase begins. An address outside the window, or in the wrong space, leaves every output of the block undriven.

Top module: `bus32_target`

## Requirements
- R1: After a synchronous active-low reset the block drives nothing: `ctl_oe`=0, `rdata_oe`=0, `rdy`=1, `size32_n`=1, `size16_n`=1, `slv_burst_n`=1, and every word of the register array reads 0.
- R2: At a clock edge with `start_n`=0, `is_mem` equal to `MEM_SPACE` (1 = memory) and `BASE_ADDR` <= `addr` < `BASE_ADDR`+`WIN_BYTES`, the card is selected. From the next cycle `ctl_oe`=1, `slv_burst_n`=0 and, for the default 32-bit build, `size32_n`=0 with `size16_n`=1.
- R3: A start phase whose address lies outside the window, or whose space does not match, selects nothing. All outputs stay in the R1 idle values and the array is not written.
- R4: With `wait_cfg`=N (0..3), every beat of a selected cycle shows `rdy`=0 for N command-phase cycles and then `rdy`=1 for one cycle. The beat transfers at the clock edge that ends that ready cycle.
- R5: A write beat changes byte lane i (bits 8i+7..8i) of the addressed word only when `be_n[i]`=0. The other lanes keep their value.
- R6: During a selected read beat `rdata_oe`=1 while `cmd_n`=0, and `rdata` carries the full addressed word. `rdata_oe` is 0 in every other case.
- R7: If `mst_burst_n`=0 at a beat's transfer edge, a further beat follows at the next word address, wrapping from the last word of the window to the first. Its wait count restarts.
- R8: If `mst_burst_n`=1 at a transfer edge, the cycle completes. `rdy` stays 1, `rdata_oe` stays 0, and no further writes occur while `cmd_n` remains low.
- R9: Releasing `cmd_n` ends the cycle, even in the middle of the wait states of a beat. No transfer happens for that beat, and `ctl_oe` returns to 0 after the next edge.
- R10: A start phase that arrives while a cycle is in progress abandons the old beat without a transfer and decodes the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Active-low start phase strobe |
| cmd_n | input | 1 | Active-low command phase strobe |
| addr | input | ADDR_W | Byte address, sampled in the start phase |
| is_mem | input | 1 | Space qualifier: 1 memory, 0 I/O |
| wr | input | 1 | 1 write, 0 read, sampled in the start phase |
| be_n | input | 4 | Active-low byte lane enables for write beats |
| mst_burst_n | input | 1 | Active-low burst accept from the master |
| wait_cfg | input | WAIT_W | Wait states inserted before each beat |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not enabled |
| rdata_oe | output | 1 | Read data output enable |
| rdy | output | 1 | Ready; low adds a wait state |
| size32_n | output | 1 | Active-low 32-bit target size report |
| size16_n | output | 1 | Active-low 16-bit target size report |
| slv_burst_n | output | 1 | Active-low burst offer |
| ctl_oe | output | 1 | Enable for rdy, size and burst-offer outputs |

## Verification
The hardest cases to reach are a burst that wraps from the last word of the window back to the first, and a beat cut short either by the release of the command line or by a new start phase in the middle of its wait states. The stimulus runs multi-beat bursts that begin near the top of the window and sweeps every wait count. It also drives transactions that are dropped after a chosen number of wait cycles. Reading back the words those writes would have touched shows, through the ports alone, that the array was left alone.

// File: rtl/bus32_target_pkg.sv
// Package: shared types of the bus target.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package bus32_target_pkg;

    // Sequencer phase of the target.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // not selected, outputs released
        ST_BEAT = 2'd1,   // selected, a data beat pending
        ST_DONE = 2'd2    // selected, last beat moved, awaiting release
    } tgt_state_e;

endpackage

// File: rtl/bus32_target_decode.sv
// Module: address window decoder.
// Says whether a start-phase address falls in the card's window and space,
// and gives the word index inside that window.
// Assumes WIN_BYTES is a power of two of at least 4 and that the window is
// aligned to its size.
module bus32_target_decode #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int                WIN_BYTES = 64,
    parameter bit                MEM_SPACE = 1'b1,
    localparam int               IDX_W     = $clog2(WIN_BYTES / 4)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_mem,
    output logic              hit,
    output logic [IDX_W-1:0]  word_idx
);

    logic [ADDR_W-1:0] offset;

    // Distance above the base; an address below the base wraps to a large value.
    always_comb offset = addr - BASE_ADDR;

    // Window and space match.
    always_comb hit = (is_mem == MEM_SPACE) && (offset < ADDR_W'(WIN_BYTES));

    // Word index inside the window.
    always_comb word_idx = offset[IDX_W+1:2];

endmodule

// File: rtl/bus32_target_seq.sv
// Module: start/command phase sequencer.
// Selects on a start phase, counts wait states per beat, issues a transfer
// strobe, steps the word index on accepted bursts and closes the cycle.
// Assumes wait_cfg is held steady during a cycle and that CMD follows START
// without a gap.
module bus32_target_seq
    import bus32_target_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              cmd_n,
    input  logic              mst_burst_n,
    input  logic              wr,
    input  logic              hit,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WAIT_W-1:0] wait_cfg,
    output tgt_state_e        state,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              wr_q,
    output logic              rdy,
    output logic              xfer
);

    logic [WAIT_W-1:0] wcnt;
    logic              waiting;

    // A beat is still in its wait states.
    always_comb waiting = (state == ST_BEAT) && (wcnt < wait_cfg);

    // Ready low only while waits remain in a beat.
    always_comb rdy = !waiting;

    // Data moves at the edge that ends a ready beat cycle.
    always_comb xfer = (state == ST_BEAT) && !waiting && !cmd_n && start_n;

    // Phase, index and wait counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
            wr_q    <= 1'b0;
            wcnt    <= '0;
        end else if (!start_n) begin
            state   <= hit ? ST_BEAT : ST_IDLE;
            cur_idx <= word_idx;
            wr_q    <= wr;
            wcnt    <= '0;
        end else begin
            case (state)
                ST_BEAT: begin
                    if (cmd_n) begin
                        state <= ST_IDLE;
                    end else if (waiting) begin
                        wcnt <= wcnt + 1'b1;
                    end else if (!mst_burst_n) begin
                        cur_idx <= cur_idx + 1'b1;
                        wcnt    <= '0;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (cmd_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: an accepted burst beat moves to the next word and stays in a beat.
    p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !mst_burst_n) |=>
            (state == ST_BEAT && cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

    // R8: a transfer without burst accept closes the cycle.
    p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && mst_burst_n) |=> (state == ST_DONE && rdy));

    // R9: command release without a new start returns to idle.
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_n && cmd_n && state != ST_IDLE) |=> (state == ST_IDLE));

    // R4: a wait cycle inside a beat never skips the beat.
    p_wait_keeps_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !cmd_n && start_n) |=> (state == ST_BEAT && $stable(cur_idx)));

endmodule

// File: rtl/bus32_target_regs.sv
// Module: byte-lane register array behind the target.
// Synchronous write with per-lane active-low enables, combinational read.
// Assumes DEPTH is a power of two matching the index width.
module bus32_target_regs #(
    parameter int  DEPTH = 16,
    parameter int  LANES = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int DW    = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [LANES-1:0] be_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rword
);

    logic [DEPTH-1:0][DW-1:0] mem;

    // Read the addressed word.
    always_comb rword = mem[idx];

    genvar g_lane;
    generate
        for (g_lane = 0; g_lane < LANES; g_lane++) begin : g_lanes
            // One byte lane: cleared on reset, written when enabled.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int w = 0; w < DEPTH; w++) mem[w][g_lane*8 +: 8] <= 8'h00;
                end else if (we && !be_n[g_lane]) begin
                    mem[idx][g_lane*8 +: 8] <= wdata[g_lane*8 +: 8];
                end
            end

            // R5: a disabled lane keeps its contents across a write.
            p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (we && be_n[g_lane]) |=> $stable(mem[$past(idx)][g_lane*8 +: 8]));
        end
    endgenerate

    // R8: no write strobe, no change anywhere in the array.
    p_array_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));

endmodule

// File: rtl/bus32_target.sv
// Module: top of the burst-capable 32-bit bus target.
// Joins the window decoder, the phase sequencer and the register array, and
// forms the bus-side outputs with their enables.
// Assumes one target per window and a master that keeps CMD low across beats.
module bus32_target
    import bus32_target_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_1000,
    parameter int                WIN_BYTES = 64,
    parameter bit                MEM_SPACE = 1'b1,
    parameter bit                WIDE32    = 1'b1,
    parameter int                WAIT_W    = 2,
    localparam int               LANES     = 4,
    localparam int               DW        = LANES * 8,
    localparam int               DEPTH     = WIN_BYTES / 4,
    localparam int               IDX_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              cmd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_mem,
    input  logic              wr,
    input  logic [LANES-1:0]  be_n,
    input  logic              mst_burst_n,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              rdata_oe,
    output logic              rdy,
    output logic              size32_n,
    output logic              size16_n,
    output logic              slv_burst_n,
    output logic              ctl_oe
);

    logic             hit;
    logic [IDX_W-1:0] dec_idx;
    tgt_state_e       state;
    logic [IDX_W-1:0] cur_idx;
    logic             wr_q;
    logic             seq_rdy;
    logic             xfer;
    logic [DW-1:0]    rword;
    logic             active;

    bus32_target_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .WIN_BYTES(WIN_BYTES),
        .MEM_SPACE(MEM_SPACE)
    ) u_decode (
        .addr    (addr),
        .is_mem  (is_mem),
        .hit     (hit),
        .word_idx(dec_idx)
    );

    bus32_target_seq #(
        .IDX_W (IDX_W),
        .WAIT_W(WAIT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_n    (start_n),
        .cmd_n      (cmd_n),
        .mst_burst_n(mst_burst_n),
        .wr         (wr),
        .hit        (hit),
        .word_idx   (dec_idx),
        .wait_cfg   (wait_cfg),
        .state      (state),
        .cur_idx    (cur_idx),
        .wr_q       (wr_q),
        .rdy        (seq_rdy),
        .xfer       (xfer)
    );

    bus32_target_regs #(
        .DEPTH(DEPTH),
        .LANES(LANES)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (xfer && wr_q),
        .idx  (cur_idx),
        .be_n (be_n),
        .wdata(wdata),
        .rword(rword)
    );

    // Card is selected in any non-idle phase.
    always_comb active = (state != ST_IDLE);

    // Control outputs and their enable.
    always_comb begin
        ctl_oe      = active;
        slv_burst_n = !active;
        rdy         = seq_rdy;
    end

    // Read data is driven only in a selected read beat under CMD.
    always_comb begin
        rdata_oe = (state == ST_BEAT) && !wr_q && !cmd_n;
        rdata    = rdata_oe ? rword : '0;
    end

    generate
        if (WIDE32) begin : g_size32
            // Report 32-bit width while selected.
            always_comb begin
                size32_n = !active;
                size16_n = 1'b1;
            end
        end else begin : g_size16
            // Report 16-bit width while selected.
            always_comb begin
                size32_n = 1'b1;
                size16_n = !active;
            end
        end
    endgenerate

    // R3: a missed decode leaves the bus outputs undriven.
    p_quiet_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_n && !hit) |=> (!ctl_oe && !rdata_oe && rdy));

    // R2: a decoded hit drives the control outputs from the next cycle.
    p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_n && hit) |=> (ctl_oe && !slv_burst_n && (size32_n != size16_n)));

    // R6: read data enable only while CMD is low and the card drives control.
    p_oe_under_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!cmd_n && ctl_oe));

endmodule

// File: tb/bus32_target_test.sv
// Bench: sweeps wait counts, words, byte enables, bursts, window misses and
// aborted cycles against a shadow model of the register array.
module bus32_target_test;

    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam int          WIN   = 64;
    localparam int          DEPTH = WIN / 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_n, cmd_n, is_mem, wr, mst_burst_n;
    logic [31:0] addr, wdata, rdata;
    logic [3:0]  be_n;
    logic [1:0]  wait_cfg;
    logic        rdata_oe, rdy, size32_n, size16_n, slv_burst_n, ctl_oe;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] shadow [DEPTH];

    always #2 clk = ~clk;

    bus32_target #(.BASE_ADDR(BASE), .WIN_BYTES(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmd_n(cmd_n),
        .addr(addr), .is_mem(is_mem), .wr(wr), .be_n(be_n),
        .mst_burst_n(mst_burst_n), .wait_cfg(wait_cfg), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .rdy(rdy), .size32_n(size32_n),
        .size16_n(size16_n), .slv_burst_n(slv_burst_n), .ctl_oe(ctl_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply strobes after a falling edge, settle, then let the caller sample.
    task automatic drive(input logic s, input logic c, input logic mb);
        @(negedge clk);
        start_n = s; cmd_n = c; mst_burst_n = mb;
        #1;
    endtask

    function automatic logic [31:0] mkdata(input logic [31:0] a, input int k);
        return (a * 32'h0009_E377) ^ (32'h0101_0101 * 32'(k + 1)) ^ 32'(wait_cfg);
    endfunction

    task automatic idle_check(input string tag);
        chk({tag, " ctl_oe idle"}, 32'(ctl_oe), 0);
        chk({tag, " rdata_oe idle"}, 32'(rdata_oe), 0);
        chk({tag, " rdy idle"}, 32'(rdy), 1);
        chk({tag, " size32_n idle"}, 32'(size32_n), 1);
    endtask

    // One cycle: start phase, beats, completion, release.
    // abort_at >= 0 releases CMD after that many cycles of the first beat.
    task automatic xact(input logic [31:0] a, input logic mem, input logic w,
                        input int beats, input bit burst, input bit sel,
                        input int abort_at);
        int idx;
        logic [31:0] d;
        idx = int'(((a - BASE) >> 2) % DEPTH);
        @(negedge clk);
        start_n = 1'b0; cmd_n = 1'b1; mst_burst_n = 1'b1;
        addr = a; is_mem = mem; wr = w;
        #1;
        for (int k = 0; k < beats; k++) begin
            for (int j = 0; j <= int'(wait_cfg); j++) begin
                if (k == 0 && j == abort_at) begin
                    drive(1'b1, 1'b1, 1'b1);
                    chk("R9 ctl_oe before release edge", 32'(ctl_oe), 32'(sel));
                    drive(1'b1, 1'b1, 1'b1);
                    idle_check("R9 after release");
                    return;
                end
                d = mkdata(a, k);
                @(negedge clk);
                start_n = 1'b1; cmd_n = 1'b0; wdata = d;
                mst_burst_n = (burst && k < beats - 1) ? 1'b0 : 1'b1;
                #1;
                if (sel) begin
                    chk("R2 ctl_oe selected", 32'(ctl_oe), 1);
                    chk("R2 size32_n selected", 32'(size32_n), 0);
                    chk("R2 size16_n selected", 32'(size16_n), 1);
                    chk("R2 slv_burst_n selected", 32'(slv_burst_n), 0);
                    chk("R4 rdy in beat", 32'(rdy), 32'(j == int'(wait_cfg)));
                    chk("R6 rdata_oe in beat", 32'(rdata_oe), 32'(!w));
                    if (j == int'(wait_cfg)) begin
                        if (!w) begin
                            chk(k > 0 ? "R7 burst read data" : "R6 read data", rdata, shadow[idx]);
                        end else begin
                            for (int l = 0; l < 4; l++)
                                if (!be_n[l]) shadow[idx][l*8 +: 8] = d[l*8 +: 8];
                        end
                    end
                end else begin
                    idle_check("R3 miss beat");
                end
            end
            idx = (idx + 1) % DEPTH;
        end
        // Command still low after the last beat: nothing more happens.
        @(negedge clk);
        start_n = 1'b1; cmd_n = 1'b0; mst_burst_n = 1'b1; wdata = ~wdata;
        #1;
        chk("R8 rdy after completion", 32'(rdy), 1);
        chk("R8 rdata_oe after completion", 32'(rdata_oe), 0);
        chk("R8 ctl_oe held until release", 32'(ctl_oe), 32'(sel));
        drive(1'b1, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
        idle_check("R9 released");
    endtask

    task automatic read_word(input int i, input string tag);
        logic [31:0] a;
        a = BASE + 32'(i * 4);
        @(negedge clk);
        start_n = 1'b0; cmd_n = 1'b1; mst_burst_n = 1'b1; addr = a; is_mem = 1'b1; wr = 1'b0;
        #1;
        for (int j = 0; j <= int'(wait_cfg); j++) drive(1'b1, 1'b0, 1'b1);
        chk({tag, " readback"}, rdata, shadow[i]);
        drive(1'b1, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        int guard;
        guard = 0;
        fork
            begin
                rst_n = 1'b0; start_n = 1'b1; cmd_n = 1'b1; addr = '0; is_mem = 1'b1;
                wr = 1'b0; be_n = 4'h0; mst_burst_n = 1'b1; wait_cfg = 2'd0; wdata = '0;
                for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
                repeat (3) @(negedge clk);
                #1;
                idle_check("R1 in reset");
                @(negedge clk);
                rst_n = 1'b1;
                #1;
                idle_check("R1 after reset");
                read_word(5, "R1 array cleared");

                // Every wait count, every word, write then read.
                for (int wc = 0; wc < 4; wc++) begin
                    wait_cfg = 2'(wc);
                    be_n = 4'h0;
                    for (int i = 0; i < DEPTH; i++) xact(BASE + 32'(i * 4), 1'b1, 1'b1, 1, 0, 1, -1);
                    for (int i = 0; i < DEPTH; i++) xact(BASE + 32'(i * 4), 1'b1, 1'b0, 1, 0, 1, -1);
                end

                // All byte enable patterns on one word.
                wait_cfg = 2'd1;
                for (int b = 0; b < 16; b++) begin
                    be_n = 4'(b);
                    xact(BASE + 32'd28, 1'b1, 1'b1, 1, 0, 1, -1);
                    read_word(7, "R5 lane write");
                end
                be_n = 4'h0;

                // Bursts at each wait count, then one that wraps the window.
                for (int wc = 0; wc < 4; wc++) begin
                    wait_cfg = 2'(wc);
                    xact(BASE + 32'd8, 1'b1, 1'b1, 4, 1, 1, -1);
                    xact(BASE + 32'd8, 1'b1, 1'b0, 4, 1, 1, -1);
                end
                wait_cfg = 2'd2;
                xact(BASE + 32'd56, 1'b1, 1'b1, 5, 1, 1, -1);
                read_word(15, "R7 wrap top");
                read_word(0, "R7 wrap bottom");
                read_word(2, "R7 wrap end");
                xact(BASE + 32'd60, 1'b1, 1'b0, 3, 1, 1, -1);

                // Misses: below, at end, far above, wrong space.
                wait_cfg = 2'd1;
                xact(BASE - 32'd4, 1'b1, 1'b1, 1, 0, 0, -1);
                xact(BASE + 32'(WIN), 1'b1, 1'b1, 1, 0, 0, -1);
                xact(BASE + 32'h100, 1'b1, 1'b1, 1, 0, 0, -1);
                xact(BASE, 1'b0, 1'b1, 1, 0, 0, -1);
                read_word(0, "R3 miss left array");
                read_word(15, "R3 miss left top word");

                // Command released in the wait states: no write.
                wait_cfg = 2'd3;
                xact(BASE + 32'd12, 1'b1, 1'b1, 1, 0, 1, 1);
                read_word(3, "R9 aborted write");

                // New start during a beat: old write dropped, new one decoded.
                @(negedge clk);
                start_n = 1'b0; cmd_n = 1'b1; addr = BASE + 32'd20; is_mem = 1'b1; wr = 1'b1;
                #1;
                drive(1'b1, 1'b0, 1'b1);
                chk("R10 first beat waiting", 32'(rdy), 0);
                xact(BASE + 32'd40, 1'b1, 1'b1, 1, 0, 1, -1);
                read_word(5, "R10 dropped beat");
                read_word(10, "R10 redecoded write");
            end
            begin
                while (guard < 100000) begin
                    @(posedge clk);
                    guard++;
                end
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<100000 cycles", guard);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule